// File: doc/BRIEF.md
# Watchdog and Wake-up Reset Controller

This block supervises the reset and clock-enable of a small key-scanning controller. It holds the CPU in reset while a shared timer measures the oscillator settling time, after power-up or after a wake from stop. When that time is up it releases the CPU, which starts from address zero. While the CPU runs, the same timer acts as a watchdog. Software keeps it from firing by driving the remote-output data bit from low to high. If the timer reaches overflow without such a transition, the block forces a full reset.

The timer is a `CNT_W`-bit counter. It advances once per `PRESCALE` system clocks. With the default values, the settling window is 12 x 1024 = 12288 clocks and a full count is 12 x 8192 = 98304 clocks.

A stop request is honoured only while every synchronised key input is inactive. In stop mode the oscillator-enable drops, the scan port is forced low and the remote driver is released. Any key input pulled low turns the oscillator back on at once, through logic with no clock in the path. Once the key is seen through the synchroniser, the settling count begins again.

Top module: `wake_wdog_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cpu_rst`=1, `running`=0, `stop_mode`=0 and `osc_en`=1.
- R2: `cpu_rst` falls and `running` rises exactly PRESCALE*STAB_TICKS clocks after the last clock edge on which `rst` was sampled high.
- R3: In run mode with no servicing, the reset fires when the counter overflows. This is PRESCALE*(2^CNT_W - STAB_TICKS) clocks after release, because the count continues from the settling value.
- R4: A rising edge on `rem_data` (0 on the previous edge, 1 on this one) during run clears both the prescaler and the counter. The next overflow then comes exactly PRESCALE*2^CNT_W clocks after the servicing edge.
- R5: A watchdog overflow holds `cpu_rst` high for one extra clock before a fresh settling count. `cpu_rst` therefore stays high for 1 + PRESCALE*STAB_TICKS clocks.
- R6: `stop_req` in run mode with all synchronised keys inactive (all `key_n` bits 1) enters stop mode on the next edge. In stop mode `stop_mode`=1, `osc_en`=0, `cpu_rst`=1 and `running`=0.
- R7: `stop_req` is ignored while any key, after two synchronising flops, is low. The block stays in run mode.
- R8: In stop mode, any `key_n` bit at 0 sets `osc_en` at once, with no clock edge. Stop mode ends on the third clock edge after the key falls. `cpu_rst` is then released PRESCALE*STAB_TICKS clocks after the edge that cleared `stop_mode`.
- R9: In stop mode `scan_o` is all zero and `rem_oe`=0. Otherwise `scan_o` equals `scan_d` and `rem_oe`=1.
- R10: Rising edges on `rem_data` during the settling window do not move the release time.
- R11: `stop_req` outside run mode is ignored: `stop_mode` stays 0 and the release time is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset request |
| stop_req | input | 1 | One-clock stop request strobe from the CPU |
| key_n | input | KEY_W | Active-low key sense inputs |
| rem_data | input | 1 | Remote-output data bit written by software |
| scan_d | input | SCAN_W | Scan port value from the CPU |
| cpu_rst | output | 1 | Reset to the CPU core |
| osc_en | output | 1 | Oscillator enable |
| stop_mode | output | 1 | Stop mode is active |
| running | output | 1 | CPU is executing |
| scan_o | output | SCAN_W | Scan port after stop gating |
| rem_oe | output | 1 | Remote output driver enable |

## Verification
The properties assume that `stop_req` is a strobe issued only by a running CPU. They also assume that each key level is held long enough to pass the two-flop synchroniser before it is expected to matter. Under that assumption, a stop refusal can be judged from the key value two edges earlier.

The bench changes inputs only at falling clock edges. It holds each key level for at least three edges before it pulses `stop_req` or expects a wake. It uses short timer parameters so that every overflow and settling window fits in the run while keeping the same arithmetic relations.

// File: rtl/wake_wdog_pkg.sv
package wake_wdog_pkg;

    typedef enum logic [1:0] {
        WS_HOLD = 2'd0,
        WS_RUN  = 2'd1,
        WS_STOP = 2'd2,
        WS_BITE = 2'd3
    } wdog_state_e;

    typedef struct packed {
        logic stab_done;
        logic wrap;
    } tmr_evt_t;

    typedef struct packed {
        logic cpu_rst;
        logic stop_mode;
        logic running;
    } wdog_stat_t;

    function automatic logic rise_of(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

    function automatic wdog_stat_t decode_state(input wdog_state_e st);
        wdog_stat_t s;
        s.running   = (st == WS_RUN);
        s.stop_mode = (st == WS_STOP);
        s.cpu_rst   = (st != WS_RUN);
        return s;
    endfunction

endpackage

// File: rtl/wake_wdog_timer.sv
module wake_wdog_timer
    import wake_wdog_pkg::*;
#(
    parameter int PRESCALE   = 12,
    parameter int CNT_W      = 13,
    parameter int STAB_TICKS = 1024
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    output tmr_evt_t evt
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0]    PRE_LAST  = PW'(PRESCALE - 1);
    localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_TICKS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

    logic [PW-1:0]    pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        evt.stab_done = tick && (cnt_q == STAB_LAST);
        evt.wrap      = tick && (cnt_q == CNT_MAX);
    end

endmodule

// File: rtl/wake_wdog_keysync.sv
module wake_wdog_keysync #(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key_n,
    output logic             key_act
);
    logic [KEY_W-1:0] meta_q;
    logic [KEY_W-1:0] sync_q;

    for (genvar i = 0; i < KEY_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b1;
                sync_q[i] <= 1'b1;
            end else begin
                meta_q[i] <= key_n[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign key_act = ~&sync_q;

endmodule

// File: rtl/wake_wdog_fsm.sv
module wake_wdog_fsm
    import wake_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        stop_req,
    input  logic        key_act,
    input  logic        svc,
    input  tmr_evt_t    evt,
    output wdog_state_e st,
    output logic        clr
);
    wdog_state_e st_q;
    wdog_state_e st_d;

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        unique case (st_q)
            WS_HOLD: begin
                if (evt.stab_done) begin
                    st_d = WS_RUN;
                end
            end
            WS_RUN: begin
                if (stop_req && !key_act) begin
                    st_d = WS_STOP;
                    clr  = 1'b1;
                end else if (svc) begin
                    clr  = 1'b1;
                end else if (evt.wrap) begin
                    st_d = WS_BITE;
                    clr  = 1'b1;
                end
            end
            WS_BITE: begin
                st_d = WS_HOLD;
                clr  = 1'b1;
            end
            WS_STOP: begin
                clr = 1'b1;
                if (key_act) begin
                    st_d = WS_HOLD;
                end
            end
            default: begin
                st_d = WS_HOLD;
                clr  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= WS_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/wake_wdog_padgate.sv
module wake_wdog_padgate #(
    parameter int SCAN_W = 8
) (
    input  logic              stop_mode,
    input  logic [SCAN_W-1:0] scan_d,
    output logic [SCAN_W-1:0] scan_o,
    output logic              rem_oe
);
    for (genvar i = 0; i < SCAN_W; i++) begin : g_scan
        assign scan_o[i] = scan_d[i] & ~stop_mode;
    end

    assign rem_oe = ~stop_mode;

endmodule

// File: rtl/wake_wdog_top.sv
module wake_wdog_top
    import wake_wdog_pkg::*;
#(
    parameter int PRESCALE   = 12,
    parameter int CNT_W      = 13,
    parameter int STAB_TICKS = 1024,
    parameter int KEY_W      = 8,
    parameter int SCAN_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic [KEY_W-1:0]  key_n,
    input  logic              rem_data,
    input  logic [SCAN_W-1:0] scan_d,
    output logic              cpu_rst,
    output logic              osc_en,
    output logic              stop_mode,
    output logic              running,
    output logic [SCAN_W-1:0] scan_o,
    output logic              rem_oe
);
    wdog_state_e st;
    wdog_stat_t  stat;
    tmr_evt_t    evt;
    logic        clr;
    logic        key_act;
    logic        rem_prev_q;
    logic        svc;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_prev_q <= 1'b0;
        end else begin
            rem_prev_q <= rem_data;
        end
    end

    assign svc = rise_of(rem_data, rem_prev_q);

    wake_wdog_keysync #(.KEY_W(KEY_W)) keysync_i (
        .clk     (clk),
        .rst     (rst),
        .key_n   (key_n),
        .key_act (key_act)
    );

    wake_wdog_timer #(
        .PRESCALE   (PRESCALE),
        .CNT_W      (CNT_W),
        .STAB_TICKS (STAB_TICKS)
    ) timer_i (
        .clk (clk),
        .rst (rst),
        .clr (clr),
        .evt (evt)
    );

    wake_wdog_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .key_act  (key_act),
        .svc      (svc),
        .evt      (evt),
        .st       (st),
        .clr      (clr)
    );

    assign stat      = decode_state(st);
    assign cpu_rst   = stat.cpu_rst;
    assign stop_mode = stat.stop_mode;
    assign running   = stat.running;

    // wake path bypasses every flop: a low key restarts the oscillator
    assign osc_en = ~stat.stop_mode | ~&key_n;

    wake_wdog_padgate #(.SCAN_W(SCAN_W)) padgate_i (
        .stop_mode (stat.stop_mode),
        .scan_d    (scan_d),
        .scan_o    (scan_o),
        .rem_oe    (rem_oe)
    );

endmodule

// File: rtl/wake_wdog_chk.sv
module wake_wdog_chk #(
    parameter int KEY_W  = 8,
    parameter int SCAN_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_req,
    input logic [KEY_W-1:0]  key_n,
    input logic              rem_data,
    input logic              cpu_rst,
    input logic              osc_en,
    input logic              stop_mode,
    input logic              running,
    input logic [SCAN_W-1:0] scan_o,
    input logic              rem_oe
);
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_mode) |-> $past(running) && $past(stop_req)); // R6

    AST_STOP_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
        stop_mode |-> cpu_rst && !running); // R6

    AST_OSC_OFF_ONLY_STOP: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> stop_mode); // R6

    AST_STOP_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (running && stop_req && !(&$past(key_n, 2))) |=> !stop_mode); // R7

    AST_WAKE_OSC: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !(&key_n)) |-> osc_en); // R8

    AST_PAD_QUIET: assert property (@(posedge clk) disable iff (rst)
        stop_mode |-> (scan_o == '0) && !rem_oe); // R9

    AST_BITE_LONG: assert property (@(posedge clk) disable iff (rst)
        ($rose(cpu_rst) && !stop_mode) |=> cpu_rst); // R5

    AST_SERVICE_SAFE: assert property (@(posedge clk) disable iff (rst)
        (running && rem_data && !$past(rem_data) && !stop_req) |=> running); // R4

endmodule

bind wake_wdog_top wake_wdog_chk #(.KEY_W(KEY_W), .SCAN_W(SCAN_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .stop_req  (stop_req),
    .key_n     (key_n),
    .rem_data  (rem_data),
    .cpu_rst   (cpu_rst),
    .osc_en    (osc_en),
    .stop_mode (stop_mode),
    .running   (running),
    .scan_o    (scan_o),
    .rem_oe    (rem_oe)
);

// File: tb/wake_wdog_top_tb_top.sv
module wake_wdog_top_tb_top;
    localparam int P    = 3;
    localparam int W    = 8;
    localparam int STAB = 16;
    localparam int KW   = 8;
    localparam int SW   = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          stop_req;
    logic [KW-1:0] key_n;
    logic          rem_data;
    logic [SW-1:0] scan_d;
    logic          cpu_rst;
    logic          osc_en;
    logic          stop_mode;
    logic          running;
    logic [SW-1:0] scan_o;
    logic          rem_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wake_wdog_top #(
        .PRESCALE(P), .CNT_W(W), .STAB_TICKS(STAB), .KEY_W(KW), .SCAN_W(SW)
    ) dut_i (
        .clk(clk), .rst(rst), .stop_req(stop_req), .key_n(key_n),
        .rem_data(rem_data), .scan_d(scan_d), .cpu_rst(cpu_rst),
        .osc_en(osc_en), .stop_mode(stop_mode), .running(running),
        .scan_o(scan_o), .rem_oe(rem_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset values
    task automatic t_reset();
        rst = 1'b1; stop_req = 1'b0; key_n = '1; rem_data = 1'b0; scan_d = 8'hA5;
        negs(3);
        chk("R1 cpu_rst", cpu_rst, 1);
        chk("R1 running", running, 0);
        chk("R1 stop_mode", stop_mode, 0);
        chk("R1 osc_en", osc_en, 1);
        rst = 1'b0;
        negs(1);
        chk("R1 cpu_rst after release", cpu_rst, 1);
    endtask

    // R2 with R10 and R11 stimulus inside the settling window
    task automatic t_stab();
        negs(4);
        rem_data = 1'b1;
        negs(5);
        rem_data = 1'b0;
        negs(1);
        stop_req = 1'b1;
        negs(1);
        stop_req = 1'b0;
        chk("R11 stop ignored in hold", stop_mode, 0);
        negs(P*STAB - 1 - 12);
        chk("R2 R10 still held", cpu_rst, 1);
        negs(1);
        chk("R2 R10 released", cpu_rst, 0);
        chk("R2 running", running, 1);
        chk("R9 run pads", {rem_oe, scan_o}, {1'b1, scan_d});
    endtask

    // R3 timeout then R5 bite length
    task automatic t_timeout();
        negs(P*((1 << W) - STAB) - 1);
        chk("R3 before overflow", running, 1);
        negs(1);
        chk("R3 overflow reset", cpu_rst, 1);
        negs(P*STAB);
        chk("R5 bite still held", cpu_rst, 1);
        negs(1);
        chk("R5 bite released", running, 1);
    endtask

    // R4 servicing by a rising edge
    task automatic t_service();
        negs(10);
        rem_data = 1'b1;
        negs(5);
        rem_data = 1'b0;
        negs(P*(1 << W) - 5);
        chk("R4 serviced still running", running, 1);
        negs(1);
        chk("R4 overflow after service", cpu_rst, 1);
        negs(P*STAB + 1);
        chk("R4 recovered", running, 1);
    endtask

    // R7 stop refused while a key is held
    task automatic t_stop_reject();
        key_n = 8'hEF;
        negs(3);
        stop_req = 1'b1;
        negs(1);
        stop_req = 1'b0;
        negs(2);
        chk("R7 no stop", stop_mode, 0);
        chk("R7 still running", running, 1);
        key_n = '1;
        negs(3);
    endtask

    // R6 stop entry, R9 pads, R8 wake
    task automatic t_stop_wake();
        int n;
        scan_d = 8'h3C;
        stop_req = 1'b1;
        negs(1);
        stop_req = 1'b0;
        chk("R6 stop_mode", stop_mode, 1);
        chk("R6 osc_en", osc_en, 0);
        chk("R6 cpu_rst", cpu_rst, 1);
        chk("R6 running", running, 0);
        chk("R9 scan low", scan_o, 0);
        chk("R9 rem released", rem_oe, 0);
        negs(10);
        chk("R6 stays stopped", stop_mode, 1);
        key_n = 8'h7F;
        #1;
        chk("R8 osc immediate", osc_en, 1);
        chk("R8 not yet woken", stop_mode, 1);
        n = 0;
        while (stop_mode && n < 6) begin
            negs(1);
            n++;
        end
        chk("R8 wake edges", n, 3);
        key_n = '1;
        negs(P*STAB - 1);
        chk("R8 settle held", cpu_rst, 1);
        negs(1);
        chk("R8 settle released", running, 1);
        chk("R9 pads restored", {rem_oe, scan_o}, {1'b1, 8'h3C});
    endtask

    initial begin
        t_reset();
        t_stab();
        t_timeout();
        t_service();
        t_stop_reject();
        t_stop_wake();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule